// File: doc/BRIEF.md
# Serial Program/Verify Port

This block is the device-side serial programming port of a microcontroller whose program words are 14 bits wide. It watches a serial clock pin, a serial data pin and a detector that reports the reset pin at programming voltage. When the reset pin rises to that level while both serial pins are low, the block enters program/verify mode and starts its address counter at zero. From then on the host sends 6-bit commands. Some commands are followed by a 14-bit data frame that the host shifts in or that the device shifts out.

The block drives an address, a write-data word and one-cycle read and write strobes toward the program memory. Through the same commands it also reaches the four identification words at 2000h–2003h, which are not reachable from normal execution. When code protection is on, reads of ordinary program memory return zeros. All pins are brought through two-flop synchronizers into the system clock domain. Serial data is taken on the falling edge of the serial clock, and read data is launched on the rising edge.

The controller has four states. OFF means outside program mode. CMD collects a command. LOAD takes in a data frame. READ shifts a data frame out. Its transitions are: ENTER (OFF to CMD), TO_LOAD and TO_READ (CMD to a data state after a framed command), EXEC (CMD to CMD after a command without a frame), FRAME_END (LOAD or READ back to CMD after the 16th falling edge), and EXIT (any state to OFF when the programming voltage goes away).

Top module: `icsp_slave`

## Requirements
- R1: Program mode is entered only when the programming-voltage detector rises while both the serial clock and the serial data pins are low. A rise with either pin high leaves the block outside the mode.
- R2: On entry, `prog_mode` goes high and `mem_addr` is 0.
- R3: Commands are 6 bits long, least significant bit first, sampled on falling serial clock edges. The codes are: 000000 load configuration, 000010 load data, 000100 read data, 000110 increment address, 001000 begin programming.
- R4: A load-data command is followed by a 16-clock frame made of a start bit, 14 data bits sent least significant bit first, and a stop bit. At the end of the frame the word appears on `mem_wdata`.
- R5: Begin programming gives exactly one one-cycle `mem_wr` pulse, with the current address and the latched word on the memory outputs.
- R6: Increment address adds one to `mem_addr`.
- R7: Read data pulses `mem_rd` and then shifts the word out least significant bit first. `pgd_oe` is high from the rising edge of the 2nd frame clock until the rising edge of the 16th frame clock and low otherwise. Each data bit is valid from its rising edge.
- R8: Load configuration sets `mem_addr` to 2000h and takes a data frame like load data. From there, increments reach the identification words, which can be written and read back.
- R9: With `code_protect` high, a read below 2000h shifts out zeros, while reads at 2000h and above return the true contents.
- R10: A fall of the programming-voltage detector leaves the mode, clears `mem_addr` and abandons any partial command or frame without changing `mem_wdata`.
- R11: Any other command code is ignored: no data frame follows, no strobe is given and the address does not change.
- R12: Outside program mode, `mem_wr`, `mem_rd` and `pgd_oe` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pgc_pin | input | 1 | Serial clock pin |
| pgd_in | input | 1 | Serial data pin, input side |
| vpp_hv | input | 1 | Reset pin is at programming voltage |
| code_protect | input | 1 | Code protection is enabled |
| mem_rdata | input | 14 | Program memory word at `mem_addr` |
| pgd_out | output | 1 | Serial data pin, output value |
| pgd_oe | output | 1 | Serial data pin, output enable |
| prog_mode | output | 1 | Block is in program/verify mode |
| mem_addr | output | 14 | Program memory address counter |
| mem_wdata | output | 14 | Latched word to program |
| mem_wr | output | 1 | One-cycle program strobe |
| mem_rd | output | 1 | One-cycle read strobe |

## Verification
The address increment and the exit on a falling programming voltage can land in the same system cycle. That happens when the detector drops at the same moment as the sixth falling clock edge of an increment command. The bench provokes it by releasing the programming voltage and lowering the serial clock on the same cycle, so that both pass through synchronizers of equal depth. It then judges that exit wins: the mode is left, the address reads 0 rather than having been incremented, and no strobe appears outside the mode.

// File: rtl/icsp_pkg.sv
package icsp_pkg;

    localparam int CMD_W = 6;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_CMD,
        ST_LOAD,
        ST_READ
    } icsp_state_t;

    localparam logic [CMD_W-1:0] CMD_LOAD_CFG   = 6'b000000;
    localparam logic [CMD_W-1:0] CMD_LOAD_DATA  = 6'b000010;
    localparam logic [CMD_W-1:0] CMD_READ_DATA  = 6'b000100;
    localparam logic [CMD_W-1:0] CMD_INC_ADDR   = 6'b000110;
    localparam logic [CMD_W-1:0] CMD_BEGIN_PROG = 6'b001000;

endpackage

// File: rtl/icsp_sync.sv
module icsp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/icsp_addr_ctr.sv
module icsp_addr_ctr #(
    parameter int              AW      = 14,
    parameter logic [AW-1:0]   ID_BASE = 14'h2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          set_id,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      addr <= '0;
        else if (clr)    addr <= '0;
        else if (set_id) addr <= ID_BASE;
        else if (inc)    addr <= addr + AW'(1);
    end
endmodule

// File: rtl/icsp_slave.sv
module icsp_slave
    import icsp_pkg::*;
#(
    parameter int            DW      = 14,
    parameter int            AW      = 14,
    parameter logic [AW-1:0] ID_BASE = 14'h2000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pgc_pin,
    input  logic          pgd_in,
    input  logic          vpp_hv,
    input  logic          code_protect,
    input  logic [DW-1:0] mem_rdata,
    output logic          pgd_out,
    output logic          pgd_oe,
    output logic          prog_mode,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_wr,
    output logic          mem_rd
);
    localparam int FRAME_CLKS = DW + 2;
    localparam int CNT_W      = $clog2(FRAME_CLKS + 1);

    // pin synchronization and edge detection
    logic [2:0] pins_s;
    logic       pgc_s, pgd_s, hv_s, pgc_q, hv_q;

    icsp_sync #(.W(3), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({vpp_hv, pgd_in, pgc_pin}),
        .q     (pins_s)
    );

    assign pgc_s = pins_s[0];
    assign pgd_s = pins_s[1];
    assign hv_s  = pins_s[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pgc_q <= 1'b0;
            hv_q  <= 1'b0;
        end else begin
            pgc_q <= pgc_s;
            hv_q  <= hv_s;
        end
    end

    logic sck_rise, sck_fall, entry, exit_req;
    assign sck_rise = pgc_s & ~pgc_q;
    assign sck_fall = ~pgc_s & pgc_q;
    assign entry    = hv_s & ~hv_q & ~pgc_s & ~pgd_s;
    assign exit_req = ~hv_s;

    // controller state
    icsp_state_t      st, st_n;
    logic [CNT_W-1:0] cnt;
    logic [CMD_W-1:0] cmd_sr, cmd_next;
    logic [DW-1:0]    dat_sr, rd_sr;
    logic             cmd_done, frame_done, in_frame;
    logic             clr_addr, set_id, inc_addr, rd_block;

    assign cmd_next   = {pgd_s, cmd_sr[CMD_W-1:1]};
    assign cmd_done   = (st == ST_CMD) && sck_fall && (cnt == CNT_W'(CMD_W - 1));
    assign frame_done = ((st == ST_LOAD) || (st == ST_READ)) && sck_fall
                        && (cnt == CNT_W'(FRAME_CLKS - 1));
    assign in_frame   = (cnt != '0) && (cnt <= CNT_W'(DW));
    assign rd_block   = code_protect && (mem_addr < ID_BASE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            ST_OFF: begin
                if (entry) st_n = ST_CMD;                       // ENTER
            end
            ST_CMD: begin
                if (exit_req) st_n = ST_OFF;                    // EXIT
                else if (cmd_done) begin
                    case (cmd_next)
                        CMD_LOAD_DATA,
                        CMD_LOAD_CFG:  st_n = ST_LOAD;          // TO_LOAD
                        CMD_READ_DATA: st_n = ST_READ;          // TO_READ
                        default:       st_n = ST_CMD;           // EXEC
                    endcase
                end
            end
            ST_LOAD, ST_READ: begin
                if (exit_req)        st_n = ST_OFF;             // EXIT
                else if (frame_done) st_n = ST_CMD;             // FRAME_END
            end
        endcase
    end

    always_comb begin
        mem_wr   = cmd_done && !exit_req && (cmd_next == CMD_BEGIN_PROG);
        mem_rd   = cmd_done && !exit_req && (cmd_next == CMD_READ_DATA);
        inc_addr = cmd_done && !exit_req && (cmd_next == CMD_INC_ADDR);
        set_id   = cmd_done && !exit_req && (cmd_next == CMD_LOAD_CFG);
        clr_addr = (st == ST_OFF) ? entry : exit_req;
    end

    assign prog_mode = (st != ST_OFF);

    // serial datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            cmd_sr    <= '0;
            dat_sr    <= '0;
            rd_sr     <= '0;
            mem_wdata <= '0;
            pgd_oe    <= 1'b0;
        end else begin
            if ((st == ST_OFF) || exit_req)  cnt <= '0;
            else if (sck_fall)               cnt <= (cmd_done || frame_done) ? '0 : cnt + CNT_W'(1);

            if ((st == ST_CMD) && sck_fall)  cmd_sr <= cmd_next;

            if ((st == ST_LOAD) && sck_fall && in_frame)
                dat_sr <= {pgd_s, dat_sr[DW-1:1]};

            if ((st == ST_LOAD) && frame_done && !exit_req)
                mem_wdata <= dat_sr;

            if (mem_rd)
                rd_sr <= rd_block ? '0 : mem_rdata;
            else if ((st == ST_READ) && sck_fall && in_frame)
                rd_sr <= {1'b0, rd_sr[DW-1:1]};

            if ((st != ST_READ) || exit_req)                    pgd_oe <= 1'b0;
            else if (sck_rise && (cnt == CNT_W'(1)))            pgd_oe <= 1'b1;
            else if (sck_rise && (cnt == CNT_W'(FRAME_CLKS-1))) pgd_oe <= 1'b0;
        end
    end

    assign pgd_out = pgd_oe & rd_sr[0];

    icsp_addr_ctr #(.AW(AW), .ID_BASE(ID_BASE)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr_addr),
        .set_id (set_id),
        .inc    (inc_addr),
        .addr   (mem_addr)
    );
endmodule

// File: rtl/icsp_slave_chk.sv
module icsp_slave_chk
    import icsp_pkg::*;
#(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prog_mode,
    input logic          pgd_oe,
    input logic          mem_wr,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic          inc_addr,
    input icsp_state_t   st
);
    a_r2_entry_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_mode) |-> (mem_addr == '0));

    a_r12_quiet_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode |-> (!mem_wr && !mem_rd && !pgd_oe));

    a_r10_addr_clear_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_mode |-> (mem_addr == '0));

    a_r7_drive_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        pgd_oe |-> (st == ST_READ));

    a_r6_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc_addr |=> (mem_addr == $past(mem_addr) + AW'(1)));

    a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));
endmodule

bind icsp_slave icsp_slave_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_mode (prog_mode),
    .pgd_oe    (pgd_oe),
    .mem_wr    (mem_wr),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .inc_addr  (inc_addr),
    .st        (st)
);

// File: tb/sim_icsp_slave.sv
`timescale 1ns/1ps
module sim_icsp_slave;
    localparam int HALF = 6;
    localparam int NV   = 6;
    localparam logic [13:0] VEC [NV] = '{14'h2A5B, 14'h0001, 14'h3FFF, 14'h1234, 14'h2000, 14'h0C3C};

    logic clk = 1'b0, rst_n = 1'b0;
    logic pgc = 1'b0, pgd_drv = 1'b0, vpp = 1'b0, cp = 1'b0;
    logic [13:0] mem_rdata, mem_addr, mem_wdata;
    logic pgd_out, pgd_oe, prog_mode, mem_wr, mem_rd;
    logic [13:0] mem [16];
    int checks = 0, errors = 0, wr_cnt = 0, stray = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    icsp_slave u0 (
        .clk(clk), .rst_n(rst_n), .pgc_pin(pgc), .pgd_in(pgd_drv), .vpp_hv(vpp),
        .code_protect(cp), .mem_rdata(mem_rdata), .pgd_out(pgd_out), .pgd_oe(pgd_oe),
        .prog_mode(prog_mode), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_wr(mem_wr), .mem_rd(mem_rd)
    );

    function automatic int midx(logic [13:0] a);
        return a[13] ? 8 + int'(a[1:0]) : int'(a[2:0]);
    endfunction

    assign mem_rdata = mem[midx(mem_addr)];

    initial for (int i = 0; i < 16; i++) mem[i] = 14'h1000 + 14'(i);

    always @(posedge clk) begin
        if (mem_wr) begin
            mem[midx(mem_addr)] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (!prog_mode && (mem_wr || mem_rd || pgd_oe)) stray <= stray + 1;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(logic b);
        pgd_drv = b; pgc = 1'b1; wait_clk(HALF);
        pgc = 1'b0; wait_clk(HALF);
    endtask

    task automatic send(int v, int n);
        for (int i = 0; i < n; i++) clk_bit(1'((v >> i) & 1));
    endtask

    task automatic load_word(logic [13:0] w);
        clk_bit(1'b0);
        send(int'(w), 14);
        clk_bit(1'b0);
    endtask

    task automatic read_word(output logic [13:0] w, output int bad);
        bad = 0; w = '0;
        for (int k = 1; k <= 16; k++) begin
            pgd_drv = 1'b0; pgc = 1'b1; wait_clk(HALF);
            if (pgd_oe !== ((k >= 2) && (k <= 15))) bad++;
            if (k >= 2 && k <= 15) w[k-2] = pgd_out;
            pgc = 1'b0; wait_clk(HALF);
        end
        if (pgd_oe !== 1'b0) bad++;
    endtask

    task automatic enter(logic sck_lvl, logic sdi_lvl);
        vpp = 1'b0; pgc = sck_lvl; pgd_drv = sdi_lvl; wait_clk(HALF);
        vpp = 1'b1; wait_clk(HALF);
        pgc = 1'b0; pgd_drv = 1'b0; wait_clk(HALF);
    endtask

    task automatic leave();
        vpp = 1'b0; wait_clk(HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [13:0] w;
        int bad;
        wait_clk(5); rst_n = 1'b1; wait_clk(2);

        chk("R12 reset prog_mode", int'(prog_mode), 0);
        chk("R12 reset oe", int'(pgd_oe), 0);
        chk("R2 reset addr", int'(mem_addr), 0);

        // R1: entry refused with clock or data high
        enter(1'b1, 1'b0);
        chk("R1 clock high blocks entry", int'(prog_mode), 0);
        send(4, 6); send(0, 16);
        leave();
        enter(1'b0, 1'b1);
        chk("R1 data high blocks entry", int'(prog_mode), 0);
        leave();

        enter(1'b0, 1'b0);
        chk("R1 entry", int'(prog_mode), 1);
        chk("R2 addr zero on entry", int'(mem_addr), 0);

        // table walk: R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            send(2, 6); load_word(VEC[i]);
            chk("R4 latched word", int'(mem_wdata), int'(VEC[i]));
            send(8, 6);
            chk("R6 address", int'(mem_addr), i);
            send(4, 6); read_word(w, bad);
            chk("R7 read data", int'(w), int'(VEC[i]));
            chk("R7 drive window", bad, 0);
            send(6, 6);
        end
        chk("R5 write pulses", wr_cnt, NV);
        chk("R6 address after walk", int'(mem_addr), NV);

        // R11: unknown command consumes no frame
        send(6'b001010, 6);
        chk("R11 addr unchanged", int'(mem_addr), NV);
        send(4, 6); read_word(w, bad);
        chk("R11 next read aligned", int'(w), 14'h1006);
        chk("R11 no write", wr_cnt, NV);

        // R8: identification words
        send(0, 6); load_word(14'h00A5);
        chk("R8 addr to ID base", int'(mem_addr), 14'h2000);
        send(8, 6);
        send(6, 6);
        chk("R8 increment in ID space", int'(mem_addr), 14'h2001);
        send(2, 6); load_word(14'h003C); send(8, 6);
        send(4, 6); read_word(w, bad);
        chk("R8 ID readback", int'(w), 14'h003C);

        // R9: code protection
        cp = 1'b1;
        send(4, 6); read_word(w, bad);
        chk("R9 ID readable when protected", int'(w), 14'h003C);
        leave(); enter(1'b0, 1'b0);
        chk("R10 addr zero after re-entry", int'(mem_addr), 0);
        send(4, 6); read_word(w, bad);
        chk("R9 protected read zero", int'(w), 0);
        cp = 1'b0;
        send(4, 6); read_word(w, bad);
        chk("R9 unprotected read", int'(w), int'(VEC[0]));

        // R10: abort a partial frame
        send(2, 6); clk_bit(1'b0); send(14'h1555, 5);
        leave();
        chk("R10 mode left", int'(prog_mode), 0);
        chk("R10 addr cleared", int'(mem_addr), 0);
        chk("R10 wdata kept", int'(mem_wdata), 14'h003C);
        enter(1'b0, 1'b0);
        send(4, 6); read_word(w, bad);
        chk("R10 fresh command after abort", int'(w), int'(VEC[0]));

        // exit coinciding with the final edge of an increment
        send(6, 6);
        chk("R6 increment to one", int'(mem_addr), 1);
        send(6, 5);
        pgd_drv = 1'b0; pgc = 1'b1; wait_clk(HALF);
        pgc = 1'b0; vpp = 1'b0; wait_clk(HALF);
        chk("R10 exit wins over increment mode", int'(prog_mode), 0);
        chk("R10 exit wins over increment addr", int'(mem_addr), 0);

        chk("R12 no activity outside mode", stray, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule